// File: doc/BRIEF.md
# Triggered Command FIFO Arbiter

This block sits between a set of command FIFOs and three command consumers: two on-chip converter command buffers and an external serial link. A FIFO takes part in arbitration only after it has been armed, either by a software write pulse or by a hardware trigger line, and it stays armed until software disables it. The top two bits of each FIFO's head command name its consumer. Each consumer has its own arbiter. Among the armed FIFOs whose head names that consumer, the lowest-numbered FIFO wins. The winner's head word is offered on a valid/ready stream. It is popped only in a cycle where the consumer asserts ready.

In the other direction, the block steers result words back to their owners. Each result carries a FIFO tag, a side-port flag and an external-source flag. A converter result with the side-port flag set goes to the parallel side port. Every other result goes to the result FIFO named by its tag. A result from the external source never leaves through the side port, because it bypasses the formatting path. The three command arbiters and the result router are purely combinational. The only state in the block is the per-FIFO armed bits.

Top module: `cmd_fifo_arbiter`

## Requirements
- R1: A pulse on `sw_trig[i]` or `hw_trig[i]` sets the armed bit of FIFO i on the next clock, and `trig_active[i]` shows it. Reset clears every armed bit.
- R2: A FIFO whose armed bit is clear is never granted and never popped, even when its head is valid.
- R3: Bits [CMD_W-1:CMD_W-2] of the head word choose the consumer: 00 = converter 0 (index 0), 01 = converter 1 (index 1), 10 = external link (index 2). A head carrying 11 is never forwarded.
- R4: When several armed FIFOs with valid heads name the same consumer, the one with the lowest index is offered on that consumer's `dst_valid`/`dst_data`.
- R5: `cq_pop[i]` is high only in a cycle where FIFO i is the winner for a consumer whose `dst_ready` is high. `dst_valid` does not depend on `dst_ready`. At most one word reaches each consumer per cycle.
- R6: `sw_disable[i]` clears the armed bit on the next clock and overrides a trigger in the same cycle. A trigger to a FIFO that is already armed leaves the state unchanged.
- R7: A valid result with `res_side` set and `res_ext` clear appears on `side_valid`/`side_data`, and no result FIFO strobe fires.
- R8: A valid result with `res_ext` set goes to result FIFO `res_tag` whatever `res_side` holds. So does a result with both flags clear.
- R9: A valid result that should go to a result FIFO is dropped when its tag is not below the number of FIFOs. No strobe fires.
- R10: The three consumers are arbitrated independently, so up to three different FIFOs can be popped in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_trig | input | NQ | Software arm pulse, one bit per FIFO |
| hw_trig | input | NQ | Hardware arm pulse, one bit per FIFO |
| sw_disable | input | NQ | Software disarm pulse, one bit per FIFO |
| trig_active | output | NQ | Armed state per FIFO |
| cq_valid | input | NQ | Head word present, per FIFO |
| cq_data | input | NQ*CMD_W | Head words, FIFO i at [i*CMD_W +: CMD_W] |
| cq_pop | output | NQ | Head consumed this cycle, per FIFO |
| dst_valid | output | 3 | Word offered to each consumer (0, 1 = converters, 2 = external) |
| dst_data | output | 3*CMD_W | Offered word, consumer d at [d*CMD_W +: CMD_W]; zero when idle |
| dst_ready | input | 3 | Consumer accepts a word |
| res_valid | input | 1 | Result word present |
| res_data | input | RES_W | Result payload |
| res_tag | input | TAG_W | Owning FIFO index |
| res_side | input | 1 | Side-port request |
| res_ext | input | 1 | Result came from the external source |
| rf_valid | output | NQ | Write strobe per result FIFO |
| rf_data | output | RES_W | Result FIFO write data |
| side_valid | output | 1 | Side-port strobe |
| side_data | output | RES_W | Side-port data |

## Verification
The bench first uses directed patterns, each meant to separate one rule from the others:
- Two armed FIFOs contend for one consumer, which isolates fixed priority.
- Three FIFOs name three different consumers in one cycle, which shows that the arbiters are independent.
- A valid head stays unarmed, and a head carries the unused code 11, which tells gating apart from decoding.
- Ready is held low while valid stays up, which separates the offer from the pop.
- Disable and trigger arrive in the same cycle, which shows which one wins.
- Results cover every combination of the side and external flags, plus out-of-range tags, which separates side routing, the bypass and dropping.

A long pseudo-random phase then mixes all of these. A behavioural model compares every output on every cycle.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
    localparam int NUM_DEST = 3;

    typedef enum logic [1:0] {
        DST_CONV0 = 2'b00,
        DST_CONV1 = 2'b01,
        DST_EXT   = 2'b10,
        DST_NONE  = 2'b11
    } dest_e;
endpackage

// File: rtl/cfa_trigger_ctrl.sv
module cfa_trigger_ctrl #(
    parameter int NQ = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] sw_trig,
    input  logic [NQ-1:0] hw_trig,
    input  logic [NQ-1:0] sw_disable,
    output logic [NQ-1:0] armed
);
    typedef struct packed {
        logic [NQ-1:0] armed;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NQ; i++) begin
            if (sw_disable[i]) begin
                st_d.armed[i] = 1'b0;
            end else if (sw_trig[i] || hw_trig[i]) begin
                st_d.armed[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;

    // R6: a disable pulse leaves the bit clear on the next cycle
    p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_disable) |=> ((st_q.armed & $past(sw_disable)) == '0));

    // R1: a trigger without a disable arms the FIFO
    p_trigger_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|((sw_trig | hw_trig) & ~sw_disable)) |=>
        ((st_q.armed & $past((sw_trig | hw_trig) & ~sw_disable)) ==
          $past((sw_trig | hw_trig) & ~sw_disable)));

    // R1: an armed bit never appears without a trigger
    p_no_spurious_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed & ~$past(st_q.armed) & ~$past(sw_trig | hw_trig)) == '0);
endmodule

// File: rtl/cfa_dest_arbiter.sv
module cfa_dest_arbiter #(
    parameter int         NQ        = 6,
    parameter int         CMD_W     = 32,
    parameter logic [1:0] DEST_CODE = 2'b00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    armed,
    input  logic [NQ-1:0]    head_valid,
    input  logic [NQ*CMD_W-1:0] head_data,
    input  logic             dst_ready,
    output logic             dst_valid,
    output logic [CMD_W-1:0] dst_data,
    output logic [NQ-1:0]    grant,
    output logic [NQ-1:0]    pop
);
    localparam int CODE_LSB = CMD_W - 2;

    logic [NQ-1:0] req;
    logic          found;

    always_comb begin
        for (int i = 0; i < NQ; i++) begin
            req[i] = armed[i] && head_valid[i] &&
                     (head_data[i*CMD_W + CODE_LSB +: 2] == DEST_CODE);
        end
    end

    always_comb begin
        grant = '0;
        found = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        dst_data = '0;
        for (int i = 0; i < NQ; i++) begin
            if (grant[i]) dst_data = head_data[i*CMD_W +: CMD_W];
        end
    end

    assign dst_valid = |grant;
    assign pop       = grant & {NQ{dst_ready}};

    // R5: one winner per consumer
    p_one_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: only armed FIFOs with valid heads win
    p_grant_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~(armed & head_valid)) == '0);

    // R5: popping requires the consumer to be ready
    p_pop_needs_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|pop) |-> dst_ready);
endmodule

// File: rtl/cfa_result_router.sv
module cfa_result_router #(
    parameter int NQ    = 6,
    parameter int RES_W = 16,
    parameter int TAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [RES_W-1:0] res_data,
    input  logic [TAG_W-1:0] res_tag,
    input  logic             res_side,
    input  logic             res_ext,
    output logic [NQ-1:0]    rf_valid,
    output logic [RES_W-1:0] rf_data,
    output logic             side_valid,
    output logic [RES_W-1:0] side_data
);
    localparam logic [TAG_W:0] NQ_LIM = (TAG_W+1)'(NQ);

    logic to_side;
    logic to_fifo;

    always_comb begin
        to_side = res_valid && res_side && !res_ext;
        to_fifo = res_valid && !to_side && ({1'b0, res_tag} < NQ_LIM);
        for (int i = 0; i < NQ; i++) begin
            rf_valid[i] = to_fifo && (res_tag == TAG_W'(i));
        end
    end

    assign side_valid = to_side;
    assign rf_data    = res_data;
    assign side_data  = res_data;

    // R7: a result leaves through at most one path
    p_route_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({side_valid, rf_valid}));

    // R8: external-source results never reach the side port
    p_ext_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_ext |-> !side_valid);

    // R9: out-of-range tags produce no strobe
    p_tag_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, res_tag} >= NQ_LIM) |-> (rf_valid == '0));
endmodule

// File: rtl/cmd_fifo_arbiter.sv
module cmd_fifo_arbiter
    import cfa_pkg::*;
#(
    parameter int NQ    = 6,
    parameter int CMD_W = 32,
    parameter int RES_W = 16,
    parameter int TAG_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NQ-1:0]             sw_trig,
    input  logic [NQ-1:0]             hw_trig,
    input  logic [NQ-1:0]             sw_disable,
    output logic [NQ-1:0]             trig_active,
    input  logic [NQ-1:0]             cq_valid,
    input  logic [NQ*CMD_W-1:0]       cq_data,
    output logic [NQ-1:0]             cq_pop,
    output logic [NUM_DEST-1:0]       dst_valid,
    output logic [NUM_DEST*CMD_W-1:0] dst_data,
    input  logic [NUM_DEST-1:0]       dst_ready,
    input  logic                      res_valid,
    input  logic [RES_W-1:0]          res_data,
    input  logic [TAG_W-1:0]          res_tag,
    input  logic                      res_side,
    input  logic                      res_ext,
    output logic [NQ-1:0]             rf_valid,
    output logic [RES_W-1:0]          rf_data,
    output logic                      side_valid,
    output logic [RES_W-1:0]          side_data
);
    logic [NQ-1:0] armed;
    logic [NQ-1:0] grant_w [NUM_DEST];
    logic [NQ-1:0] pop_w   [NUM_DEST];

    cfa_trigger_ctrl #(.NQ(NQ)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_trig    (sw_trig),
        .hw_trig    (hw_trig),
        .sw_disable (sw_disable),
        .armed      (armed)
    );

    for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
        cfa_dest_arbiter #(
            .NQ        (NQ),
            .CMD_W     (CMD_W),
            .DEST_CODE (2'(d))
        ) u_arb (
            .clk        (clk),
            .rst_n      (rst_n),
            .armed      (armed),
            .head_valid (cq_valid),
            .head_data  (cq_data),
            .dst_ready  (dst_ready[d]),
            .dst_valid  (dst_valid[d]),
            .dst_data   (dst_data[d*CMD_W +: CMD_W]),
            .grant      (grant_w[d]),
            .pop        (pop_w[d])
        );
    end

    always_comb begin
        cq_pop = '0;
        for (int d = 0; d < NUM_DEST; d++) begin
            cq_pop = cq_pop | pop_w[d];
        end
    end

    assign trig_active = armed;

    cfa_result_router #(
        .NQ    (NQ),
        .RES_W (RES_W),
        .TAG_W (TAG_W)
    ) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_tag    (res_tag),
        .res_side   (res_side),
        .res_ext    (res_ext),
        .rf_valid   (rf_valid),
        .rf_data    (rf_data),
        .side_valid (side_valid),
        .side_data  (side_data)
    );

    // R3: a FIFO head is granted by at most one consumer
    p_single_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_w[0] & grant_w[1]) | (grant_w[0] & grant_w[2]) |
         (grant_w[1] & grant_w[2])) == '0);

    // R2: no pop from an unarmed FIFO
    p_pop_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cq_pop & ~trig_active) == '0);
endmodule

// File: tb/cmd_fifo_arbiter_test.sv
module cmd_fifo_arbiter_test;
    localparam int NQ    = 6;
    localparam int CMD_W = 32;
    localparam int RES_W = 16;
    localparam int TAG_W = 3;
    localparam int ND    = 3;
    localparam int DEPTH = 32;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NQ-1:0]         sw_trig = '0, hw_trig = '0, sw_disable = '0;
    logic [NQ-1:0]         trig_active;
    logic [NQ-1:0]         cq_valid = '0;
    logic [NQ*CMD_W-1:0]   cq_data = '0;
    logic [NQ-1:0]         cq_pop;
    logic [ND-1:0]         dst_valid;
    logic [ND*CMD_W-1:0]   dst_data;
    logic [ND-1:0]         dst_ready = '0;
    logic                  res_valid = 1'b0;
    logic [RES_W-1:0]      res_data = '0;
    logic [TAG_W-1:0]      res_tag = '0;
    logic                  res_side = 1'b0, res_ext = 1'b0;
    logic [NQ-1:0]         rf_valid;
    logic [RES_W-1:0]      rf_data;
    logic                  side_valid;
    logic [RES_W-1:0]      side_data;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    logic [CMD_W-1:0] mem [NQ][DEPTH];
    int hd [NQ];
    int tl [NQ];
    bit armed_m [NQ];

    always #5 clk = ~clk;

    cmd_fifo_arbiter #(.NQ(NQ), .CMD_W(CMD_W), .RES_W(RES_W), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig), .hw_trig(hw_trig),
        .sw_disable(sw_disable), .trig_active(trig_active), .cq_valid(cq_valid),
        .cq_data(cq_data), .cq_pop(cq_pop), .dst_valid(dst_valid), .dst_data(dst_data),
        .dst_ready(dst_ready), .res_valid(res_valid), .res_data(res_data),
        .res_tag(res_tag), .res_side(res_side), .res_ext(res_ext), .rf_valid(rf_valid),
        .rf_data(rf_data), .side_valid(side_valid), .side_data(side_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (phase %s) actual=%0h expected=%0h t=%0t", req, phase, act, exp, $time);
        end
    endtask

    task automatic push(input int q, input logic [1:0] dest, input logic [29:0] pay);
        mem[q][tl[q] % DEPTH] = {dest, pay};
        tl[q]++;
    endtask

    function automatic int summary_line();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        return 0;
    endfunction

    // One cycle: inputs are already set after a negedge; compare, update model, advance.
    task automatic step();
        logic [NQ-1:0] exp_pop, exp_arm, exp_rf;
        logic [ND-1:0] exp_v;
        logic [CMD_W-1:0] exp_d [ND];
        bit exp_side;
        int dummy;
        for (int i = 0; i < NQ; i++) begin
            cq_valid[i] = (hd[i] != tl[i]);
            cq_data[i*CMD_W +: CMD_W] = cq_valid[i] ? mem[i][hd[i] % DEPTH] : '0;
        end
        #1;
        exp_pop = '0;
        for (int i = 0; i < NQ; i++) exp_arm[i] = armed_m[i];
        for (int d = 0; d < ND; d++) begin
            exp_v[d] = 1'b0;
            exp_d[d] = '0;
            for (int i = 0; i < NQ; i++) begin
                if (!exp_v[d] && armed_m[i] && hd[i] != tl[i] &&
                    int'(mem[i][hd[i] % DEPTH][CMD_W-1 -: 2]) == d) begin
                    exp_v[d] = 1'b1;
                    exp_d[d] = mem[i][hd[i] % DEPTH];
                    if (dst_ready[d]) exp_pop[i] = 1'b1;
                end
            end
        end
        chk(trig_active == exp_arm, "R1", 64'(trig_active), 64'(exp_arm));
        chk(dst_valid == exp_v, "R3", 64'(dst_valid), 64'(exp_v));
        for (int d = 0; d < ND; d++)
            if (exp_v[d])
                chk(dst_data[d*CMD_W +: CMD_W] == exp_d[d], "R4",
                    64'(dst_data[d*CMD_W +: CMD_W]), 64'(exp_d[d]));
        chk(cq_pop == exp_pop, "R5", 64'(cq_pop), 64'(exp_pop));
        exp_side = res_valid && res_side && !res_ext;
        exp_rf = '0;
        if (res_valid && !exp_side && int'(res_tag) < NQ) exp_rf[res_tag] = 1'b1;
        chk(side_valid == exp_side, "R7", 64'(side_valid), 64'(exp_side));
        chk(rf_valid == exp_rf, "R8", 64'(rf_valid), 64'(exp_rf));
        if (exp_side) chk(side_data == res_data, "R7", 64'(side_data), 64'(res_data));
        if (exp_rf != '0) chk(rf_data == res_data, "R8", 64'(rf_data), 64'(res_data));
        for (int i = 0; i < NQ; i++) begin
            if (exp_pop[i]) hd[i]++;
            if (sw_disable[i]) armed_m[i] = 1'b0;
            else if (sw_trig[i] || hw_trig[i]) armed_m[i] = 1'b1;
        end
        @(negedge clk);
        sw_trig = '0; hw_trig = '0; sw_disable = '0; res_valid = 1'b0;
        dummy = 0;
    endtask

    initial begin
        int dummy;
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        dummy = summary_line();
        $finish;
    end

    initial begin
        int dummy;
        for (int i = 0; i < NQ; i++) begin hd[i] = 0; tl[i] = 0; armed_m[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(trig_active == '0, "R1", 64'(trig_active), 64'd0);
        chk(dst_valid == '0, "R1", 64'(dst_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: valid heads, nothing armed
        phase = "R2";
        dst_ready = 3'b111;
        push(1, 2'b00, 30'h11); push(3, 2'b00, 30'h33);
        repeat (2) step();

        // R4: FIFO 3 armed by software first, then FIFO 1 by hardware; lower index wins
        phase = "R4";
        dst_ready = 3'b000;
        sw_trig[3] = 1'b1; step();
        hw_trig[1] = 1'b1; step();
        step();
        dst_ready = 3'b001; step();
        step();

        // R6: retrigger has no effect; disable beats trigger in same cycle
        phase = "R6";
        sw_trig[1] = 1'b1; step();
        sw_trig[3] = 1'b1; sw_disable[3] = 1'b1; step();
        chk(trig_active[3] == 1'b0, "R6", 64'(trig_active[3]), 64'd0);
        push(3, 2'b00, 30'h34); step();

        // R10 and R3: three FIFOs, three consumers, one cycle
        phase = "R10";
        push(0, 2'b10, 30'h100); push(2, 2'b01, 30'h200); push(4, 2'b00, 30'h400);
        sw_trig[0] = 1'b1; sw_trig[2] = 1'b1; hw_trig[4] = 1'b1;
        dst_ready = 3'b000; step();
        dst_ready = 3'b111; step();
        step();

        // R3: destination code 11 is never forwarded
        phase = "R3";
        push(5, 2'b11, 30'h555); sw_trig[5] = 1'b1; step();
        repeat (2) step();
        sw_disable[5] = 1'b1; step();
        hd[5] = tl[5];

        // R7, R8, R9: result routing
        phase = "R7";
        res_valid = 1; res_tag = 3'd2; res_side = 1; res_ext = 0; res_data = 16'hA1; step();
        phase = "R8";
        res_valid = 1; res_tag = 3'd4; res_side = 1; res_ext = 1; res_data = 16'hB2; step();
        res_valid = 1; res_tag = 3'd0; res_side = 0; res_ext = 0; res_data = 16'hC3; step();
        res_valid = 1; res_tag = 3'd5; res_side = 0; res_ext = 1; res_data = 16'hC4; step();
        phase = "R9";
        res_valid = 1; res_tag = 3'd6; res_side = 0; res_ext = 0; res_data = 16'hD4; step();
        res_valid = 1; res_tag = 3'd7; res_side = 0; res_ext = 1; res_data = 16'hE5; step();
        res_valid = 1; res_tag = 3'd6; res_side = 1; res_ext = 0; res_data = 16'hE6; step();

        // Mixed pseudo-random traffic (R1 to R10)
        phase = "R5";
        for (int n = 0; n < 2000; n++) begin
            for (int i = 0; i < NQ; i++) begin
                if ($urandom_range(0, 3) == 0 && (tl[i] - hd[i]) < DEPTH - 2)
                    push(i, 2'($urandom_range(0, 3)), 30'($urandom));
                sw_trig[i]    = ($urandom_range(0, 9) == 0);
                hw_trig[i]    = ($urandom_range(0, 9) == 0);
                sw_disable[i] = ($urandom_range(0, 29) == 0);
            end
            dst_ready = 3'($urandom);
            res_valid = $urandom_range(0, 1) == 1;
            res_tag   = 3'($urandom);
            res_side  = $urandom_range(0, 1) == 1;
            res_ext   = $urandom_range(0, 1) == 1;
            res_data  = 16'($urandom);
            step();
        end

        dummy = summary_line();
        $finish;
    end
endmodule